// File: doc/BRIEF.md
# Ping-Pong Transpose Buffer for a Row-Column 8x8 Transform

This block sits between the two one-dimensional passes of a separable 8x8 cosine transform. The first pass produces coefficients row by row; the second pass needs them column by column. The buffer accepts a stream of signed coefficients and stores each group of 64 in one of two memory banks, filling addresses in sequence. Once a bank holds a complete block, it is read back in transposed order: the read walks down a column, visiting every eighth address, while the next block is written into the other bank.

Upstream arithmetic has a fixed start-up latency, so the buffer has a start gate. A one-cycle start pulse opens a delay counter, and input valids are ignored until the counter expires. With default parameters the first coefficient is stored on the 15th clock edge after the start pulse is captured, and the first transposed coefficient leaves on the 79th. After that, a continuous input stream gives a continuous output stream, one block behind.

Top module: `tpb_transpose_buf`

## Requirements
- R1: After reset `out_vld` is low, and it stays low until a full block of DIM*DIM coefficients has been stored.
- R2: Calling the edge that captures `blk_start` edge 0, `in_vld` is ignored at edges 1 to START_LAT-1 (and at all edges before the start). The first coefficient that can be stored is the one presented at edge START_LAT (15 by default).
- R3: Accepted coefficients fill a bank in row-major order. The k-th accepted sample of a block (k from 0) is element row k/DIM, column k%DIM, stored at address k.
- R4: A stored block leaves in column-major order. The j-th output of a block (j from 0) is element row j%DIM, column j/DIM. The read address is the write counter with its row and column fields swapped.
- R5: With `in_vld` high from edge START_LAT onward, the first output is registered at edge START_LAT+DIM*DIM (79 by default). The block's DIM*DIM outputs then follow on consecutive edges.
- R6: The two banks alternate. The next block is written into one bank while the other is read, so a gap-free input stream yields a gap-free output stream.
- R7: When `in_vld` is low, storage pauses without losing data. A bank's output burst starts on the edge after its last coefficient is stored, provided the other bank's burst has ended.
- R8: Once the gate has opened, further `blk_start` pulses have no effect on acceptance or ordering.
- R9: No bank is written while it still holds coefficients that have not been read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| blk_start | input | 1 | One-cycle pulse marking the start of the upstream input stream |
| in_vld | input | 1 | First-pass coefficient present |
| in_coef | input | COEF_W | First-pass coefficient, signed two's complement |
| out_vld | output | 1 | Transposed coefficient present |
| out_coef | output | COEF_W | Transposed coefficient, signed two's complement |

## Verification
The no-overwrite property assumes that `in_vld` never outruns the read side by more than one bank. This holds because the read side drains a full bank at one word per cycle, and the writer can accept at most one word per cycle. The burst and fill properties also assume that `blk_start` is not raised until the internal reset release has completed. The stimulus therefore waits several cycles after reset before the start pulse, uses at most one accepted sample per clock, and mixes stalls drawn from a fixed-seed generator with directed stretches of full-rate input and extreme values.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

  // Default geometry and timing shared by the buffer and its bench.
  localparam int unsigned TPB_DIM       = 8;
  localparam int unsigned TPB_COEF_W    = 12;
  localparam int unsigned TPB_START_LAT = 15;

  // Identity of the two storage banks.
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } tpb_bank_e;

  function automatic tpb_bank_e tpb_other(input tpb_bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction

endpackage

// File: rtl/tpb_start_gate.sv
module tpb_start_gate #(
  parameter int unsigned START_LAT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_start,
  output logic armed
);

  localparam int unsigned LW = $clog2(START_LAT + 1);
  localparam logic [LW-1:0] LAT_V = LW'(START_LAT);

  logic          run_q, run_d;
  logic [LW-1:0] dly_q, dly_d;

  // Counter starts at 1 on the capturing edge and saturates at START_LAT.
  always_comb begin
    run_d = run_q;
    dly_d = dly_q;
    if (!run_q) begin
      if (blk_start) begin
        run_d = 1'b1;
        dly_d = LW'(1);
      end
    end else if (dly_q != LAT_V) begin
      dly_d = dly_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dly_q <= '0;
    end else begin
      run_q <= run_d;
      dly_q <= dly_d;
    end
  end

  assign armed = run_q && (dly_q == LAT_V);

  AST_GATE_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed); // R8

endmodule

// File: rtl/tpb_wr_ctrl.sv
module tpb_wr_ctrl
  import tpb_pkg::*;
#(
  parameter int unsigned DIM = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  output logic [$clog2(DIM*DIM)-1:0]    wr_addr,
  output tpb_bank_e                     wr_bank,
  output logic                          fill_done
);

  localparam int unsigned DEPTH = DIM * DIM;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q, addr_d;
  tpb_bank_e     bank_q, bank_d;

  assign fill_done = wr_en && (addr_q == LAST);

  always_comb begin
    addr_d = addr_q;
    bank_d = bank_q;
    if (wr_en) begin
      addr_d = fill_done ? '0 : addr_q + AW'(1);
    end
    if (fill_done) begin
      bank_d = tpb_other(bank_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bank_q <= BANK_A;
    end else begin
      addr_q <= addr_d;
      bank_q <= bank_d;
    end
  end

  assign wr_addr = addr_q;
  assign wr_bank = bank_q;

endmodule

// File: rtl/tpb_bank.sv
module tpb_bank #(
  parameter int unsigned COEF_W = 12,
  parameter int unsigned DEPTH  = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [COEF_W-1:0]        wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [COEF_W-1:0]        rdata
);

  logic [COEF_W-1:0] mem [DEPTH];

  // Storage array: written under enable, never reset.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/tpb_rd_ctrl.sv
module tpb_rd_ctrl
  import tpb_pkg::*;
#(
  parameter int unsigned DIM    = 8,
  parameter int unsigned COEF_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fill_done,
  input  tpb_bank_e                   fill_bank,
  input  logic [COEF_W-1:0]           rd_word,
  output logic [$clog2(DIM*DIM)-1:0]  rd_addr,
  output tpb_bank_e                   rd_bank,
  output logic [1:0]                  full_vec,
  output logic                        out_vld,
  output logic [COEF_W-1:0]           out_coef
);

  localparam int unsigned DEPTH = DIM * DIM;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned HW    = $clog2(DIM);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [1:0]        full_q, full_d;
  tpb_bank_e         bank_q, bank_d;
  logic [AW-1:0]     cnt_q, cnt_d;
  logic              vld_q, vld_d;
  logic [COEF_W-1:0] dat_q, dat_d;
  logic              rd_fire, rd_last;

  assign rd_fire = full_q[bank_q];
  assign rd_last = rd_fire && (cnt_q == LAST);

  // Counter is {column, row}; the bank address is {row, column}.
  assign rd_addr = {cnt_q[HW-1:0], cnt_q[AW-1:HW]};

  always_comb begin
    full_d = full_q;
    bank_d = bank_q;
    cnt_d  = cnt_q;
    vld_d  = rd_fire;
    dat_d  = dat_q;
    if (rd_fire) begin
      cnt_d = rd_last ? '0 : cnt_q + AW'(1);
      dat_d = rd_word;
    end
    if (rd_last) begin
      full_d[bank_q] = 1'b0;
      bank_d         = tpb_other(bank_q);
    end
    if (fill_done) begin
      full_d[fill_bank] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      bank_q <= BANK_A;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      full_q <= full_d;
      bank_q <= bank_d;
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
      dat_q  <= dat_d;
    end
  end

  assign rd_bank  = bank_q;
  assign full_vec = full_q;
  assign out_vld  = vld_q;
  assign out_coef = dat_q;

  AST_BURST_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && (cnt_q != LAST)) |=> out_vld && rd_fire); // R6

endmodule

// File: rtl/tpb_transpose_buf.sv
module tpb_transpose_buf
  import tpb_pkg::*;
#(
  parameter int unsigned DIM       = TPB_DIM,
  parameter int unsigned COEF_W    = TPB_COEF_W,
  parameter int unsigned START_LAT = TPB_START_LAT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_start,
  input  logic              in_vld,
  input  logic [COEF_W-1:0] in_coef,
  output logic              out_vld,
  output logic [COEF_W-1:0] out_coef
);

  localparam int unsigned DEPTH = DIM * DIM;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned NBANK = 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end

  assign rst_i_n = rs_q[1];

  logic              gate_open;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  tpb_bank_e         wr_bank;
  logic              fill_done;
  logic [AW-1:0]     rd_addr;
  tpb_bank_e         rd_bank;
  logic [1:0]        full_vec;
  logic [COEF_W-1:0] bank_rd [NBANK];
  logic [COEF_W-1:0] rd_word;

  tpb_start_gate #(
    .START_LAT(START_LAT)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .blk_start (blk_start),
    .armed     (gate_open)
  );

  assign wr_en = gate_open && in_vld;

  tpb_wr_ctrl #(
    .DIM(DIM)
  ) u_wr (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_bank   (wr_bank),
    .fill_done (fill_done)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && (wr_bank == tpb_bank_e'(b));
    tpb_bank #(
      .COEF_W(COEF_W),
      .DEPTH (DEPTH)
    ) u_mem (
      .clk   (clk),
      .we    (bank_we),
      .waddr (wr_addr),
      .wdata (in_coef),
      .raddr (rd_addr),
      .rdata (bank_rd[b])
    );
  end

  assign rd_word = bank_rd[rd_bank];

  tpb_rd_ctrl #(
    .DIM   (DIM),
    .COEF_W(COEF_W)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .fill_done (fill_done),
    .fill_bank (wr_bank),
    .rd_word   (rd_word),
    .rd_addr   (rd_addr),
    .rd_bank   (rd_bank),
    .full_vec  (full_vec),
    .out_vld   (out_vld),
    .out_coef  (out_coef)
  );

  // Records that some bank has completed; used only by the checks below.
  logic ever_filled_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ever_filled_q <= 1'b0;
    end else if (fill_done) begin
      ever_filled_q <= 1'b1;
    end
  end

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_en |-> !full_vec[wr_bank]); // R9

  AST_FILL_MARKS_FULL: assert property (@(posedge clk) disable iff (!rst_i_n)
    fill_done |=> full_vec[$past(wr_bank)]); // R6

  AST_OUT_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_i_n)
    out_vld |-> ever_filled_q); // R1

  AST_NO_EARLY_STORE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_vld && !gate_open) |=> $stable(wr_addr)); // R2

endmodule

// File: tb/tb_tpb_transpose_buf.sv
module tb_tpb_transpose_buf;

  localparam int CLK_PERIOD = 10;
  localparam int DIM   = 8;
  localparam int W     = 12;
  localparam int LAT   = 15;
  localparam int DEPTH = DIM * DIM;

  logic         clk;
  logic         rst_n;
  logic         blk_start;
  logic         in_vld;
  logic [W-1:0] in_coef;
  logic         out_vld;
  logic [W-1:0] out_coef;

  tpb_transpose_buf #(.DIM(DIM), .COEF_W(W), .START_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start),
    .in_vld(in_vld), .in_coef(in_coef),
    .out_vld(out_vld), .out_coef(out_coef)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit done_flag = 0;

  // Model state
  int edge_n = 0;
  bit started = 0;
  int e0 = 0;
  int blk_buf [DEPTH];
  int blk_cnt = 0;
  int blocks_done = 0;
  int exp_data [$];
  int exp_edge [$];
  int last_out = -1;
  bit chk_on = 0;
  int first_out_edge = -1;
  int first_out_val = -1;
  int win_cnt = 0;

  function automatic int xpose_idx(int j);
    return (j % DIM) * DIM + (j / DIM);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  // Reference model: acceptance (R2, R8), row-major fill (R3),
  // column-major emission (R4), burst timing (R5, R6, R7).
  always @(posedge clk) begin
    edge_n = edge_n + 1;
    if (blk_start && !started && rst_n) begin
      started = 1;
      e0 = edge_n;
    end
    if (started && edge_n >= e0 + LAT && in_vld) begin
      blk_buf[blk_cnt] = int'(in_coef);
      blk_cnt++;
      if (blk_cnt == DEPTH) begin
        for (int j = 0; j < DEPTH; j++) begin
          int oe;
          oe = imax(last_out + 1, edge_n + 1);
          exp_data.push_back(blk_buf[xpose_idx(j)]);
          exp_edge.push_back(oe);
          last_out = oe;
        end
        blk_cnt = 0;
        blocks_done++;
      end
    end
  end

  // Per-cycle output checker, away from the active edge.
  always @(negedge clk) begin
    if (chk_on) begin
      if (out_vld && first_out_edge < 0) begin
        first_out_edge = edge_n;
        first_out_val  = int'(out_coef);
      end
      if (started && out_vld && edge_n >= e0 + LAT + DEPTH
          && edge_n < e0 + LAT + 3 * DEPTH) begin
        win_cnt++;
      end
      if (exp_edge.size() > 0 && exp_edge[0] == edge_n) begin
        chk(out_vld === 1'b1, "R5 R6 R7 out_vld", int'(out_vld), 1);
        chk(int'(out_coef) == exp_data[0], "R3 R4 R9 data", int'(out_coef), exp_data[0]);
        void'(exp_data.pop_front());
        void'(exp_edge.pop_front());
      end else begin
        chk(out_vld === 1'b0, (blocks_done == 0) ? "R1 idle" : "R7 idle",
            int'(out_vld), 0);
      end
    end
  end

  task automatic drive(bit v, int d);
    @(negedge clk);
    in_vld  = v;
    in_coef = W'(d);
  endtask

  initial begin
    void'($urandom(32'h1A2B3C4D));
    rst_n = 1'b0;
    blk_start = 1'b0;
    in_vld = 1'b0;
    in_coef = '0;
    repeat (3) @(negedge clk);
    chk(out_vld === 1'b0, "R1 reset", int'(out_vld), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_vld === 1'b0, "R1 after reset", int'(out_vld), 0);
    chk_on = 1;

    // R2: junk before the start pulse is ignored
    for (int i = 0; i < 5; i++) drive(1'b1, int'($urandom % 4096));

    // Start pulse, junk through the gate window (R2)
    @(negedge clk);
    blk_start = 1'b1;
    in_vld = 1'b1;
    in_coef = W'(12'h7AA);
    @(negedge clk);
    blk_start = 1'b0;
    in_coef = W'(12'h155);
    for (int i = 0; i < LAT - 2; i++) drive(1'b1, int'($urandom % 4096));

    // Block 0: directed ramp at full rate (R3, R4, R5)
    for (int k = 0; k < DEPTH; k++) drive(1'b1, k * 32 - 1024);

    // Block 1: extreme values, full rate, with a second start pulse (R6, R8)
    for (int k = 0; k < DEPTH; k++) begin
      drive(1'b1, (((k ^ (k >> 3)) & 1) != 0) ? 2047 : -2048);
      blk_start = (k == 20);
    end
    blk_start = 1'b0;

    // Blocks 2..4: random data with random stalls (R7)
    for (int b = 0; b < 3; b++) begin
      int got;
      got = 0;
      while (got < DEPTH) begin
        bit v;
        v = (($urandom % 4) != 0);
        drive(v, int'($urandom % 4096));
        if (v) got++;
      end
    end
    drive(1'b0, 0);
    repeat (200) @(negedge clk);

    chk(first_out_edge == e0 + LAT + DEPTH, "R5 first output edge",
        first_out_edge - e0, LAT + DEPTH);
    chk(first_out_val == ((-1024) & 12'hFFF), "R2 R3 first output value",
        first_out_val, (-1024) & 12'hFFF);
    chk(win_cnt == 2 * DEPTH, "R6 gap-free two blocks", win_cnt, 2 * DEPTH);
    chk(exp_data.size() == 0, "R7 all blocks delivered", exp_data.size(), 0);
    chk(blocks_done == 5, "R8 blocks accepted", blocks_done, 5);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule